// File: doc/BRIEF.md
# TLB Miss and Error Classifier

This block sorts each instruction fetch and each data access into one fault outcome. The caller supplies the translation lookup result and the attributes of the matching table entry. The instruction side and the data side are two independent paths, and they can be used in the same cycle. For each request, a side reports one of four fault kinds:

- no fault;
- a TLB miss;
- a translation or protection error;
- a write to a page whose change bit is still clear (data side only).

Next to the kind, the side reports a cause field. The cause field marks exactly which condition won.

The classifier sits beside the lookup stage. It decides only *which* fault applies. Vectoring to a handler is left to the surrounding logic. With the default parameter, each result is registered. The result for a request presented at one clock edge appears after that edge and is held for one cycle.

Top module: `tlb_fault_classifier`

## Requirements

- R1: While `rst_n` is low at a clock edge, both sides clear their outputs after that edge: valid 0, kind 0, cause 0.
- R2: A request sampled at edge k is reported after edge k with the valid output set. A cycle without a request reports valid 0, kind 0 and cause 0.
- R3: A side whose translation-enable input is 0 reports kind 0 (no fault) with cause 0, whatever the lookup result and attributes are.
- R4: A fetch with translation enabled and no TLB hit reports kind 1 (miss) with cause 4'b0001. The valid, permission and guarded inputs are ignored in that case.
- R5: A fetch that hits, with either the segment valid bit or the page valid bit at 0, reports kind 2 (error) with cause 4'b0010.
- R6: A fetch that hits on valid entries but lacks execute permission reports kind 2 with cause 4'b0100.
- R7: A fetch that hits on valid entries, has execute permission and targets guarded memory reports kind 2 with cause 4'b1000.
- R8: A data access with translation enabled and no TLB hit reports kind 1 with cause 4'b0001.
- R9: A data access that hits, with a valid bit at 0, reports kind 2 with cause 4'b0010.
- R10: The data access code selects the permission that is checked:
  - store (1) and block zero (2) need write permission;
  - load (0), line store (3), flush (4), invalidate (5), instruction invalidate (6) and the spare code (7) need read permission.
  - A missing permission reports kind 2 with cause 4'b0100.
- R11: A store or block zero that passes the checks above, to a page whose change bit is 0, reports kind 3 with cause 4'b1000. The other access codes ignore the change bit.
- R12: On each side the cause field has at most one bit set. It is zero exactly when the kind is 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_req | input | 1 | Instruction fetch present this cycle |
| if_xlate_en | input | 1 | Instruction translation enabled |
| if_tlb_hit | input | 1 | Instruction TLB has a matching entry |
| if_seg_valid | input | 1 | Level-one segment valid bit of the fetch page |
| if_page_valid | input | 1 | Page valid bit of the fetch page |
| if_exec_ok | input | 1 | Fetch permitted by protection |
| if_guarded | input | 1 | Fetch page is guarded memory |
| if_flt_vld | output | 1 | Instruction result valid |
| if_kind | output | 2 | Instruction fault kind (0 none, 1 miss, 2 error) |
| if_cause | output | 4 | Instruction cause: bit0 miss, bit1 invalid, bit2 protection, bit3 guarded |
| dt_req | input | 1 | Data access present this cycle |
| dt_xlate_en | input | 1 | Data translation enabled |
| dt_tlb_hit | input | 1 | Data TLB has a matching entry |
| dt_seg_valid | input | 1 | Level-one segment valid bit of the data page |
| dt_page_valid | input | 1 | Page valid bit of the data page |
| dt_rd_ok | input | 1 | Read permitted by protection |
| dt_wr_ok | input | 1 | Write permitted by protection |
| dt_changed | input | 1 | Change bit of the data page |
| dt_acc | input | 3 | Access code, as listed in R10 |
| dt_flt_vld | output | 1 | Data result valid |
| dt_kind | output | 2 | Data fault kind (0 none, 1 miss, 2 error, 3 change) |
| dt_cause | output | 4 | Data cause: bit0 miss, bit1 invalid, bit2 protection, bit3 change |

## Verification

The assertions assume the following about the inputs:

- Every input is a defined 0 or 1 at each rising edge.
- The timing properties apply only with the registered output variant.

The lookup attributes carry meaning only together with a hit. Even so, the stimulus drives all of them freely on misses and on disabled sides, so the ignore rules are exercised. Random values are biased toward enabled translation, hits and set valid bits, so that the deeper error causes occur often. Inputs change only at the falling edge.

// File: rtl/tlbf_pkg.sv
// Package: shared encodings for the TLB fault classifier.
// Assumes: cause field is one-hot over the four winning conditions.
package tlbf_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_MISS = 2'd1,
        FK_ERR  = 2'd2,
        FK_CHG  = 2'd3
    } fault_kind_e;

    localparam int KIND_W  = 2;
    localparam int CAUSE_W = 4;
    localparam int ACC_W   = 3;

    localparam int CB_MISS  = 0;
    localparam int CB_INVAL = 1;
    localparam int CB_PROT  = 2;
    localparam int CB_ATTR  = 3;

    typedef enum logic [ACC_W-1:0] {
        AC_LOAD   = 3'd0,
        AC_STORE  = 3'd1,
        AC_ZERO   = 3'd2,
        AC_CLEAN  = 3'd3,
        AC_FLUSH  = 3'd4,
        AC_INVAL  = 3'd5,
        AC_IINVAL = 3'd6,
        AC_SPARE  = 3'd7
    } dacc_e;

    // True for access codes that modify memory contents.
    function automatic logic acc_modifies(input logic [ACC_W-1:0] acc);
        return (acc == AC_STORE) || (acc == AC_ZERO);
    endfunction

    // Cause vector with a single bit set.
    function automatic logic [CAUSE_W-1:0] cause_bit(input int idx);
        logic [CAUSE_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ifetch_classify.sv
// Module: instruction-side fault decision (combinational).
// Assumes: attribute inputs are meaningful only when hit is set;
// priority is miss, then invalid, then protection, then guarded.
module ifetch_classify
    import tlbf_pkg::*;
(
    input  logic               xlate_en,
    input  logic               tlb_hit,
    input  logic               seg_valid,
    input  logic               page_valid,
    input  logic               exec_ok,
    input  logic               guarded,
    output logic [KIND_W-1:0]  kind,
    output logic [CAUSE_W-1:0] cause
);

    // Priority chain choosing the single winning fetch condition.
    always_comb begin
        kind  = FK_NONE;
        cause = '0;
        if (xlate_en) begin
            if (!tlb_hit) begin
                kind  = FK_MISS;
                cause = cause_bit(CB_MISS);
            end else if (!seg_valid || !page_valid) begin
                kind  = FK_ERR;
                cause = cause_bit(CB_INVAL);
            end else if (!exec_ok) begin
                kind  = FK_ERR;
                cause = cause_bit(CB_PROT);
            end else if (guarded) begin
                kind  = FK_ERR;
                cause = cause_bit(CB_ATTR);
            end
        end
    end

endmodule

// File: rtl/daccess_classify.sv
// Module: data-side fault decision (combinational).
// Assumes: only store and block zero need write permission and the
// change bit; all other access codes are checked as reads.
module daccess_classify
    import tlbf_pkg::*;
(
    input  logic               xlate_en,
    input  logic               tlb_hit,
    input  logic               seg_valid,
    input  logic               page_valid,
    input  logic               rd_ok,
    input  logic               wr_ok,
    input  logic               changed,
    input  logic [ACC_W-1:0]   acc,
    output logic [KIND_W-1:0]  kind,
    output logic [CAUSE_W-1:0] cause
);

    logic writes;
    logic perm_ok;

    // Select the permission that applies to this access code.
    always_comb begin
        writes  = acc_modifies(acc);
        perm_ok = writes ? wr_ok : rd_ok;
    end

    // Priority chain choosing the single winning data condition.
    always_comb begin
        kind  = FK_NONE;
        cause = '0;
        if (xlate_en) begin
            if (!tlb_hit) begin
                kind  = FK_MISS;
                cause = cause_bit(CB_MISS);
            end else if (!seg_valid || !page_valid) begin
                kind  = FK_ERR;
                cause = cause_bit(CB_INVAL);
            end else if (!perm_ok) begin
                kind  = FK_ERR;
                cause = cause_bit(CB_PROT);
            end else if (writes && !changed) begin
                kind  = FK_CHG;
                cause = cause_bit(CB_ATTR);
            end
        end
    end

endmodule

// File: rtl/flt_out_stage.sv
// Module: optional output register for one side's result word.
// Assumes: REG_OUT=1 adds one cycle; REG_OUT=0 passes through.
module flt_out_stage #(
    parameter int W       = 7,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            // Hold the result word, cleared by synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_pass
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/tlb_fault_classifier.sv
// Module: top of the TLB miss/error classifier, two independent sides.
// Assumes: one request per side per cycle; result word is
// {valid, kind, cause} and is all zero when no request is present.
module tlb_fault_classifier
    import tlbf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_req,
    input  logic               if_xlate_en,
    input  logic               if_tlb_hit,
    input  logic               if_seg_valid,
    input  logic               if_page_valid,
    input  logic               if_exec_ok,
    input  logic               if_guarded,
    output logic               if_flt_vld,
    output logic [1:0]         if_kind,
    output logic [3:0]         if_cause,
    input  logic               dt_req,
    input  logic               dt_xlate_en,
    input  logic               dt_tlb_hit,
    input  logic               dt_seg_valid,
    input  logic               dt_page_valid,
    input  logic               dt_rd_ok,
    input  logic               dt_wr_ok,
    input  logic               dt_changed,
    input  logic [2:0]         dt_acc,
    output logic               dt_flt_vld,
    output logic [1:0]         dt_kind,
    output logic [3:0]         dt_cause
);

    localparam int RES_W = 1 + KIND_W + CAUSE_W;

    logic [KIND_W-1:0]  i_kind,  d_kind;
    logic [CAUSE_W-1:0] i_cause, d_cause;
    logic [RES_W-1:0]   i_word,  d_word;
    logic [RES_W-1:0]   i_q,     d_q;

    ifetch_classify u_if (
        .xlate_en   (if_xlate_en),
        .tlb_hit    (if_tlb_hit),
        .seg_valid  (if_seg_valid),
        .page_valid (if_page_valid),
        .exec_ok    (if_exec_ok),
        .guarded    (if_guarded),
        .kind       (i_kind),
        .cause      (i_cause)
    );

    daccess_classify u_dt (
        .xlate_en   (dt_xlate_en),
        .tlb_hit    (dt_tlb_hit),
        .seg_valid  (dt_seg_valid),
        .page_valid (dt_page_valid),
        .rd_ok      (dt_rd_ok),
        .wr_ok      (dt_wr_ok),
        .changed    (dt_changed),
        .acc        (dt_acc),
        .kind       (d_kind),
        .cause      (d_cause)
    );

    // Gate each side's decision with its request to form the result word.
    always_comb begin
        i_word = if_req ? {1'b1, i_kind, i_cause} : '0;
        d_word = dt_req ? {1'b1, d_kind, d_cause} : '0;
    end

    flt_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_if_out (
        .clk (clk), .rst_n (rst_n), .d (i_word), .q (i_q)
    );

    flt_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_dt_out (
        .clk (clk), .rst_n (rst_n), .d (d_word), .q (d_q)
    );

    assign {if_flt_vld, if_kind, if_cause} = i_q;
    assign {dt_flt_vld, dt_kind, dt_cause} = d_q;

endmodule

// File: rtl/tlb_fault_classifier_chk.sv
// Module: property checker bound to tlb_fault_classifier.
// Assumes: timing properties apply to the registered variant only.
module tlb_fault_classifier_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       if_req,
    input logic       if_xlate_en,
    input logic       if_tlb_hit,
    input logic       if_seg_valid,
    input logic       if_page_valid,
    input logic       if_exec_ok,
    input logic       if_guarded,
    input logic       if_flt_vld,
    input logic [1:0] if_kind,
    input logic [3:0] if_cause,
    input logic       dt_req,
    input logic       dt_xlate_en,
    input logic       dt_tlb_hit,
    input logic       dt_seg_valid,
    input logic       dt_page_valid,
    input logic       dt_rd_ok,
    input logic       dt_wr_ok,
    input logic       dt_changed,
    input logic [2:0] dt_acc,
    input logic       dt_flt_vld,
    input logic [1:0] dt_kind,
    input logic [3:0] dt_cause
);

    // R12
    if_cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(if_cause) && ((if_cause == 4'd0) == (if_kind == 2'd0)));

    // R12
    dt_cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dt_cause) && ((dt_cause == 4'd0) == (dt_kind == 2'd0)));

    generate
        if (REG_OUT) begin : g_timed
            // R2
            if_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !if_req |=> !if_flt_vld && if_cause == 4'd0);

            // R3
            if_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                if_req && !if_xlate_en |=> if_flt_vld && if_kind == 2'd0);

            // R4
            if_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
                if_req && if_xlate_en && !if_tlb_hit |=> if_kind == 2'd1 && if_cause == 4'b0001);

            // R7
            if_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
                if_req && if_xlate_en && if_tlb_hit && if_seg_valid && if_page_valid
                && if_exec_ok && if_guarded |=> if_kind == 2'd2 && if_cause == 4'b1000);

            // R8
            dt_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dt_req && dt_xlate_en && !dt_tlb_hit |=> dt_kind == 2'd1 && dt_cause == 4'b0001);

            // R11
            dt_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dt_req && dt_xlate_en && dt_tlb_hit && dt_seg_valid && dt_page_valid
                && dt_wr_ok && (dt_acc == 3'd1 || dt_acc == 3'd2) && !dt_changed
                |=> dt_kind == 2'd3 && dt_cause == 4'b1000);
        end
    endgenerate

endmodule

bind tlb_fault_classifier tlb_fault_classifier_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .if_req        (if_req),
    .if_xlate_en   (if_xlate_en),
    .if_tlb_hit    (if_tlb_hit),
    .if_seg_valid  (if_seg_valid),
    .if_page_valid (if_page_valid),
    .if_exec_ok    (if_exec_ok),
    .if_guarded    (if_guarded),
    .if_flt_vld    (if_flt_vld),
    .if_kind       (if_kind),
    .if_cause      (if_cause),
    .dt_req        (dt_req),
    .dt_xlate_en   (dt_xlate_en),
    .dt_tlb_hit    (dt_tlb_hit),
    .dt_seg_valid  (dt_seg_valid),
    .dt_page_valid (dt_page_valid),
    .dt_rd_ok      (dt_rd_ok),
    .dt_wr_ok      (dt_wr_ok),
    .dt_changed    (dt_changed),
    .dt_acc        (dt_acc),
    .dt_flt_vld    (dt_flt_vld),
    .dt_kind       (dt_kind),
    .dt_cause      (dt_cause)
);

// File: tb/tb_tlb_fault_classifier.sv
// Bench: directed corners plus seeded random traffic on both sides,
// compared against expected words computed from the requirements.
module tb_tlb_fault_classifier;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_req = 0, if_xlate_en = 0, if_tlb_hit = 0, if_seg_valid = 0;
    logic if_page_valid = 0, if_exec_ok = 0, if_guarded = 0;
    logic dt_req = 0, dt_xlate_en = 0, dt_tlb_hit = 0, dt_seg_valid = 0;
    logic dt_page_valid = 0, dt_rd_ok = 0, dt_wr_ok = 0, dt_changed = 0;
    logic [2:0] dt_acc = 3'd0;
    logic       if_flt_vld, dt_flt_vld;
    logic [1:0] if_kind, dt_kind;
    logic [3:0] if_cause, dt_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlb_fault_classifier dut (.*);

    // Expected instruction word {valid, kind, cause}.
    function automatic logic [6:0] exp_if(logic req, logic en, logic hit,
                                          logic sv, logic pv, logic x, logic g);
        if (!req)         return 7'd0;
        if (!en)          return {1'b1, 2'd0, 4'b0000};
        if (!hit)         return {1'b1, 2'd1, 4'b0001};
        if (!sv || !pv)   return {1'b1, 2'd2, 4'b0010};
        if (!x)           return {1'b1, 2'd2, 4'b0100};
        if (g)            return {1'b1, 2'd2, 4'b1000};
        return {1'b1, 2'd0, 4'b0000};
    endfunction

    // Expected data word {valid, kind, cause}.
    function automatic logic [6:0] exp_dt(logic req, logic en, logic hit, logic sv,
                                          logic pv, logic rd, logic wr, logic chg,
                                          logic [2:0] acc);
        logic wrt;
        wrt = (acc == 3'd1) || (acc == 3'd2);
        if (!req)                return 7'd0;
        if (!en)                 return {1'b1, 2'd0, 4'b0000};
        if (!hit)                return {1'b1, 2'd1, 4'b0001};
        if (!sv || !pv)          return {1'b1, 2'd2, 4'b0010};
        if (wrt ? !wr : !rd)     return {1'b1, 2'd2, 4'b0100};
        if (wrt && !chg)         return {1'b1, 2'd3, 4'b1000};
        return {1'b1, 2'd0, 4'b0000};
    endfunction

    // Requirement tag for a random instruction result.
    function automatic string tag_if(logic [6:0] e);
        if (!e[6])         return "R2";
        if (e[3:0] == 0)   return (e[5:4] == 0) ? "R3" : "R12";
        if (e[0])          return "R4";
        if (e[1])          return "R5";
        if (e[2])          return "R6";
        return "R7";
    endfunction

    // Requirement tag for a random data result.
    function automatic string tag_dt(logic [6:0] e);
        if (!e[6])         return "R2";
        if (e[3:0] == 0)   return "R12";
        if (e[0])          return "R8";
        if (e[1])          return "R9";
        if (e[2])          return "R10";
        return "R11";
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compute expectations, let one edge pass, compare both sides.
    task automatic step(string itag, string dtag);
        logic [6:0] ei, ed;
        ei = exp_if(if_req, if_xlate_en, if_tlb_hit, if_seg_valid, if_page_valid,
                    if_exec_ok, if_guarded);
        ed = exp_dt(dt_req, dt_xlate_en, dt_tlb_hit, dt_seg_valid, dt_page_valid,
                    dt_rd_ok, dt_wr_ok, dt_changed, dt_acc);
        @(posedge clk);
        @(negedge clk);
        check((itag == "") ? tag_if(ei) : itag, {if_flt_vld, if_kind, if_cause}, ei);
        check((dtag == "") ? tag_dt(ed) : dtag, {dt_flt_vld, dt_kind, dt_cause}, ed);
    endtask

    task automatic set_if(logic r, logic e, logic h, logic s, logic p, logic x, logic g);
        if_req = r; if_xlate_en = e; if_tlb_hit = h; if_seg_valid = s;
        if_page_valid = p; if_exec_ok = x; if_guarded = g;
    endtask

    task automatic set_dt(logic r, logic e, logic h, logic s, logic p, logic rd,
                          logic wr, logic c, logic [2:0] a);
        dt_req = r; dt_xlate_en = e; dt_tlb_hit = h; dt_seg_valid = s;
        dt_page_valid = p; dt_rd_ok = rd; dt_wr_ok = wr; dt_changed = c; dt_acc = a;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with active requests still clears outputs
        set_if(1, 1, 0, 1, 1, 1, 0);
        set_dt(1, 1, 0, 1, 1, 1, 1, 1, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {if_flt_vld, if_kind, if_cause}, 7'd0);
        check("R1", {dt_flt_vld, dt_kind, dt_cause}, 7'd0);
        rst_n = 1'b1;

        // R3: translation off hides every bad attribute
        set_if(1, 0, 0, 0, 0, 0, 1);
        set_dt(1, 0, 0, 0, 0, 0, 0, 0, 3'd1);
        step("R3", "R3");
        // R4 / R8: miss wins over invalid bits and missing permission
        set_if(1, 1, 0, 0, 0, 0, 1);
        set_dt(1, 1, 0, 0, 0, 0, 0, 0, 3'd2);
        step("R4", "R8");
        // R5 / R9: invalid segment wins over protection
        set_if(1, 1, 1, 0, 1, 0, 1);
        set_dt(1, 1, 1, 1, 0, 0, 0, 0, 3'd1);
        step("R5", "R9");
        // R6 / R10: protection wins over guarded and change
        set_if(1, 1, 1, 1, 1, 0, 1);
        set_dt(1, 1, 1, 1, 1, 1, 0, 0, 3'd1);
        step("R6", "R10");
        // R7 / R11: guarded fetch; block zero on an unchanged page
        set_if(1, 1, 1, 1, 1, 1, 1);
        set_dt(1, 1, 1, 1, 1, 0, 1, 0, 3'd2);
        step("R7", "R11");
        // R10 / R11: flush needs read only and ignores the change bit
        set_if(1, 1, 1, 1, 1, 1, 0);
        set_dt(1, 1, 1, 1, 1, 1, 0, 0, 3'd4);
        step("R12", "R11");
        // R10: instruction invalidate without read permission
        set_dt(1, 1, 1, 1, 1, 0, 1, 1, 3'd6);
        step("R12", "R10");
        // R2: idle cycle after requests reports nothing
        set_if(0, 1, 0, 0, 0, 0, 1);
        set_dt(0, 1, 0, 0, 0, 0, 0, 0, 3'd1);
        step("R2", "R2");

        // Seeded random traffic biased toward deep causes
        for (int i = 0; i < 600; i++) begin
            set_if(($urandom % 6) != 0, ($urandom % 8) != 0, ($urandom % 5) != 0,
                   ($urandom % 6) != 0, ($urandom % 6) != 0, ($urandom % 4) != 0,
                   ($urandom % 3) == 0);
            set_dt(($urandom % 6) != 0, ($urandom % 8) != 0, ($urandom % 5) != 0,
                   ($urandom % 6) != 0, ($urandom % 6) != 0, ($urandom % 4) != 0,
                   ($urandom % 4) != 0, ($urandom % 2) == 0, 3'($urandom % 8));
            step("", "");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule